// File: doc/BRIEF.md
# Hash Message Padding Formatter

This block prepares a byte-sized message for a 512-bit-block compression engine of the MD5/SHA family. It fetches the message from a word-addressed memory that holds 32-bit little-endian words, reverses the byte order of every word, and packs the words into sixteen-word blocks. It adds the terminating marker bit and zero fill, and it writes the 64-bit bit-length field into the tail of the final block. When the message ends too close to a block boundary for the length to fit, it emits an extra block that holds only padding. The hashing itself is done elsewhere.

A job starts with a one-cycle `start` strobe that carries the message base address and byte count. The block count is worked out when the job starts. Each finished block is offered on a valid/ready handshake together with a flag that marks the final block. The next block is fetched only after the current one has been accepted, so the engine downstream sets the pace.

Top module: `msg_pad_fmt`

## Requirements
- R1: For a byte count S the formatter offers exactly floor((S+8)/64)+1 blocks per job. `blk_last` is high with the final block and low with every other block, and no block is offered after the final one is accepted.
- R2: Byte reversal: the memory byte in bits [7:0] of a word lands in bits [31:24] of the block word, bits [15:8] in [23:16], bits [23:16] in [15:8], and bits [31:24] in [7:0].
- R3: Message byte k (byte j of memory word msg_addr + j/4 sits in bits [8j+7:8j], with j = k mod 4) goes to block k/64, word (k mod 64)/4, bits [31-8*(k mod 4) -: 8]. Block word w is driven on `blk_words[32w+31:32w]`.
- R4: When S mod 4 is 1, 2 or 3, the last message word keeps its top 1, 2 or 3 bytes, takes 0x80 in the next byte, and is zero below that.
- R5: When S mod 4 is 0, the word right after the message is 0x80000000. If the message fills a block to its last word, that word is word 0 of the next block.
- R6: Every byte between the marker byte and the length field is zero, including stray memory bytes past the message end in the same word.
- R7: Word 14 of the final block holds bits [63:32] of S*8 and word 15 holds bits [31:0].
- R8: Once `blk_valid` is high it stays high, with `blk_words` and `blk_last` unchanged, until a rising edge at which `blk_ready` is also high. That edge transfers the block.
- R9: Memory returns the word at `rd_addr` one cycle later. Words are read from consecutive addresses starting at `msg_addr`, at most 16 per block, with N = min(16, message words still unread). `blk_valid` rises at the (N+2)-th rising edge after the edge that takes `start` or accepts the previous block.
- R10: `start`, `msg_addr` and `msg_bytes` are ignored while a job is in progress; the running job's blocks are unchanged and no extra block appears.
- R11: A synchronous active-high `rst` drops `blk_valid` and `blk_last` at the next edge and returns to idle, from which a new `start` is taken.
- R12: A zero-byte message yields one block whose word 0 is 0x80000000 and whose other words are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job start strobe, taken when idle |
| msg_addr | input | ADDR_W | Word address of the first message word |
| msg_bytes | input | SIZE_W | Message length in bytes |
| rd_addr | output | ADDR_W | Memory read address (registered) |
| rd_data | input | 32 | Memory read data, one cycle after the address |
| blk_valid | output | 1 | Block offered |
| blk_ready | input | 1 | Block accepted when high with `blk_valid` |
| blk_last | output | 1 | Offered block is the final block of the job |
| blk_words | output | 512 | Sixteen big-endian 32-bit words, word w at bits [32w+31:32w] |

## Verification
Each block is due at a fixed edge: N+2 rising edges after the start or acceptance edge, where N is the word count read for that block. The bench counts falling edges from the stimulus edge and requires `blk_valid` exactly at count N+3. It compares words and the last flag only after `blk_valid` is seen, and after any stall it holds `blk_ready` low. The end of a job is confirmed by watching thirty further cycles for a spurious block. A reset response is sampled at the falling edge that follows the first edge with `rst` high.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int IDX_W     = $clog2(BLK_WORDS);
  localparam int CNT_W     = IDX_W + 1;
  localparam int BLK_W     = WORD_W * BLK_WORDS;
  localparam int LEN_W     = 64;
  localparam logic [WORD_W-1:0] MARK_WORD = 32'h8000_0000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_PAD,
    ST_OFFER
  } seq_state_t;

  // little-endian memory word to big-endian block word
  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] y;
    for (int i = 0; i < WORD_W/8; i++) begin
      y[8*i +: 8] = x[WORD_W-8-8*i +: 8];
    end
    return y;
  endfunction
endpackage

// File: rtl/pad_word_shaper.sv
// Byte-swaps one captured word and, for the tail word of a message whose
// length is not a multiple of four bytes, masks the stray bytes and inserts
// the marker byte (R2, R4, R6).
module pad_word_shaper
  import pad_pkg::*;
(
  input  logic [WORD_W-1:0] raw_word,
  input  logic              is_tail,
  input  logic [1:0]        tail_bytes,
  output logic [WORD_W-1:0] shaped_word
);
  logic [WORD_W-1:0] be_word;

  always_comb begin
    be_word     = swap_bytes(raw_word);
    shaped_word = be_word;
    if (is_tail) begin
      case (tail_bytes)
        2'd1:    shaped_word = {be_word[31:24], 24'h80_0000};
        2'd2:    shaped_word = {be_word[31:16], 16'h8000};
        2'd3:    shaped_word = {be_word[31:8],  8'h80};
        default: shaped_word = be_word;
      endcase
    end
  end
endmodule

// File: rtl/pad_block_buf.sv
// Sixteen-word block register. Cleared as a whole, then written by the
// capture port, the marker port and the length port.
module pad_block_buf
  import pad_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              mark_en,
  input  logic [IDX_W-1:0]  mark_idx,
  input  logic              len_en,
  input  logic [LEN_W-1:0]  len_bits,
  output logic [BLK_W-1:0]  words
);
  localparam int LEN_HI_IDX = BLK_WORDS - 2;
  localparam int LEN_LO_IDX = BLK_WORDS - 1;

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] q;
    logic              hit_len_hi;
    logic              hit_len_lo;

    assign hit_len_hi = len_en && (g == LEN_HI_IDX);
    assign hit_len_lo = len_en && (g == LEN_LO_IDX);

    always_ff @(posedge clk) begin
      if (clr) begin
        q <= '0;
      end else if (hit_len_hi) begin
        q <= len_bits[LEN_W-1:WORD_W];
      end else if (hit_len_lo) begin
        q <= len_bits[WORD_W-1:0];
      end else if (mark_en && (mark_idx == IDX_W'(g))) begin
        q <= MARK_WORD;
      end else if (cap_en && (cap_idx == IDX_W'(g))) begin
        q <= cap_word;
      end
    end

    assign words[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/pad_seq.sv
// Job sequencer: latches the job, counts blocks and words, drives the memory
// address and the block handshake, and steers the buffer write ports.
module pad_seq
  import pad_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [SIZE_W-1:0] msg_bytes,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic              blk_last,
  output logic              buf_clr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              cap_tail,
  output logic [1:0]        tail_bytes,
  output logic              mark_en,
  output logic [IDX_W-1:0]  mark_idx,
  output logic              len_en,
  output logic [LEN_W-1:0]  len_bits,
  output logic              busy,
  output logic [SIZE_W-1:0] size_q
);
  seq_state_t        state;
  logic [SIZE_W-1:0] words_left;
  logic [SIZE_W-1:0] blocks_left;
  logic [CNT_W-1:0]  take;
  logic [CNT_W-1:0]  cnt;
  logic              mark_done;

  logic [SIZE_W:0]   word_sum;
  logic [SIZE_W:0]   blk_sum;
  logic [SIZE_W-1:0] words_init;
  logic [SIZE_W-1:0] blocks_init;
  logic              final_blk;
  logic              accept;

  function automatic logic [CNT_W-1:0] blk_take(input logic [SIZE_W-1:0] left);
    if (left >= SIZE_W'(BLK_WORDS)) return CNT_W'(BLK_WORDS);
    else                            return CNT_W'(left);
  endfunction

  // job geometry from the byte count
  assign word_sum    = {1'b0, msg_bytes} + (SIZE_W+1)'(3);
  assign blk_sum     = {1'b0, msg_bytes} + (SIZE_W+1)'(8);
  assign words_init  = SIZE_W'(word_sum >> 2);
  assign blocks_init = SIZE_W'(blk_sum >> 6) + SIZE_W'(1);

  assign final_blk  = (blocks_left == SIZE_W'(1));
  assign accept     = (state == ST_OFFER) && blk_ready;
  assign busy       = (state != ST_IDLE);
  assign tail_bytes = size_q[1:0];

  // buffer steering
  assign buf_clr  = rst || ((state == ST_IDLE) && start) || (accept && !final_blk);
  assign cap_en   = (state == ST_READ) && (cnt != '0);
  assign cap_idx  = IDX_W'(cnt - CNT_W'(1));
  assign cap_tail = (words_left == SIZE_W'(1));
  assign mark_en  = (state == ST_PAD) && !mark_done && (words_left == '0) &&
                    (take != CNT_W'(BLK_WORDS)) && (size_q[1:0] == 2'd0);
  assign mark_idx = IDX_W'(take);
  assign len_en   = (state == ST_PAD) && final_blk;
  assign len_bits = LEN_W'(size_q) << 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rd_addr     <= '0;
      blk_valid   <= 1'b0;
      blk_last    <= 1'b0;
      cnt         <= '0;
      take        <= '0;
      words_left  <= '0;
      blocks_left <= '0;
      size_q      <= '0;
      mark_done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            size_q      <= msg_bytes;
            words_left  <= words_init;
            blocks_left <= blocks_init;
            take        <= blk_take(words_init);
            cnt         <= '0;
            rd_addr     <= msg_addr;
            mark_done   <= 1'b0;
            state       <= ST_READ;
          end
        end
        ST_READ: begin
          if (cnt != '0) begin
            words_left <= words_left - SIZE_W'(1);
            if (cap_tail && (size_q[1:0] != 2'd0)) mark_done <= 1'b1;
          end
          if (cnt == take) begin
            state <= ST_PAD;
          end else begin
            cnt     <= cnt + CNT_W'(1);
            rd_addr <= rd_addr + ADDR_W'(1);
          end
        end
        ST_PAD: begin
          if (mark_en) mark_done <= 1'b1;
          blk_valid <= 1'b1;
          blk_last  <= final_blk;
          state     <= ST_OFFER;
        end
        ST_OFFER: begin
          if (blk_ready) begin
            blk_valid <= 1'b0;
            blk_last  <= 1'b0;
            if (final_blk) begin
              state <= ST_IDLE;
            end else begin
              blocks_left <= blocks_left - SIZE_W'(1);
              take        <= blk_take(words_left);
              cnt         <= '0;
              state       <= ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_pad_fmt.sv
module msg_pad_fmt
  import pad_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [SIZE_W-1:0] msg_bytes,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic              blk_last,
  output logic [511:0]      blk_words
);
  logic              buf_clr;
  logic              cap_en;
  logic [IDX_W-1:0]  cap_idx;
  logic              cap_tail;
  logic [1:0]        tail_bytes;
  logic              mark_en;
  logic [IDX_W-1:0]  mark_idx;
  logic              len_en;
  logic [LEN_W-1:0]  len_bits;
  logic [WORD_W-1:0] shaped_word;
  logic              seq_busy;
  logic [SIZE_W-1:0] seq_size;

  pad_seq #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) i_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .msg_addr   (msg_addr),
    .msg_bytes  (msg_bytes),
    .rd_addr    (rd_addr),
    .blk_valid  (blk_valid),
    .blk_ready  (blk_ready),
    .blk_last   (blk_last),
    .buf_clr    (buf_clr),
    .cap_en     (cap_en),
    .cap_idx    (cap_idx),
    .cap_tail   (cap_tail),
    .tail_bytes (tail_bytes),
    .mark_en    (mark_en),
    .mark_idx   (mark_idx),
    .len_en     (len_en),
    .len_bits   (len_bits),
    .busy       (seq_busy),
    .size_q     (seq_size)
  );

  pad_word_shaper i_shaper (
    .raw_word    (rd_data),
    .is_tail     (cap_tail),
    .tail_bytes  (tail_bytes),
    .shaped_word (shaped_word)
  );

  pad_block_buf i_buf (
    .clk      (clk),
    .clr      (buf_clr),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_word (shaped_word),
    .mark_en  (mark_en),
    .mark_idx (mark_idx),
    .len_en   (len_en),
    .len_bits (len_bits),
    .words    (blk_words)
  );
endmodule

// File: rtl/pad_fmt_checker.sv
module pad_fmt_checker
  import pad_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              blk_valid,
  input logic              blk_ready,
  input logic              blk_last,
  input logic [511:0]      blk_words,
  input logic              seq_busy,
  input logic [SIZE_W-1:0] seq_size
);
  logic [SIZE_W-1:0] hs_cnt;
  logic [SIZE_W:0]   blk_sum;
  logic [SIZE_W-1:0] exp_blocks;
  logic [LEN_W-1:0]  exp_len;

  assign blk_sum    = {1'b0, seq_size} + (SIZE_W+1)'(8);
  assign exp_blocks = SIZE_W'(blk_sum >> 6) + SIZE_W'(1);
  assign exp_len    = LEN_W'(seq_size) << 3;

  always_ff @(posedge clk) begin
    if (rst || !seq_busy)            hs_cnt <= '0;
    else if (blk_valid && blk_ready) hs_cnt <= hs_cnt + SIZE_W'(1);
  end

  // R8: offered block held until accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_words) && $stable(blk_last));

  // R1: last flag only on an offered block
  a_r1_last_valid: assert property (@(posedge clk) disable iff (rst)
    blk_last |-> blk_valid);

  // R1: final block comes after exactly the expected count
  a_r1_block_count: assert property (@(posedge clk) disable iff (rst)
    blk_valid && blk_last |-> (hs_cnt + SIZE_W'(1)) == exp_blocks);

  // R7: length field in the final block
  a_r7_length: assert property (@(posedge clk) disable iff (rst)
    blk_valid && blk_last |->
      blk_words[14*32 +: 32] == exp_len[63:32] && blk_words[15*32 +: 32] == exp_len[31:0]);

  // R9: read address only steps forward by one inside a job
  a_r9_addr_step: assert property (@(posedge clk) disable iff (rst)
    seq_busy && $past(seq_busy) |-> rd_addr == $past(rd_addr) || rd_addr == $past(rd_addr) + ADDR_W'(1));

  // R11: reset clears the handshake outputs
  a_r11_reset: assert property (@(posedge clk)
    rst |=> !blk_valid && !blk_last);

  // R12: empty message block content
  a_r12_empty: assert property (@(posedge clk) disable iff (rst)
    blk_valid && seq_size == '0 |-> blk_words == {480'd0, MARK_WORD});
endmodule

bind msg_pad_fmt pad_fmt_checker #(
  .ADDR_W (ADDR_W),
  .SIZE_W (SIZE_W)
) i_pad_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_addr   (rd_addr),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .blk_last  (blk_last),
  .blk_words (blk_words),
  .seq_busy  (seq_busy),
  .seq_size  (seq_size)
);

// File: tb/test_msg_pad_fmt.sv
`timescale 1ns/1ps
module test_msg_pad_fmt;
  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [15:0]  msg_addr;
  logic [31:0]  msg_bytes;
  logic [15:0]  rd_addr;
  logic [31:0]  rd_data;
  logic         blk_valid;
  logic         blk_ready;
  logic         blk_last;
  logic [511:0] blk_words;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:255];

  always #2 clk = ~clk;  // 250 MHz

  always_ff @(posedge clk) rd_data <= mem[rd_addr[7:0]];

  msg_pad_fmt i_msg_pad_fmt (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .msg_addr  (msg_addr),
    .msg_bytes (msg_bytes),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .blk_valid (blk_valid),
    .blk_ready (blk_ready),
    .blk_last  (blk_last),
    .blk_words (blk_words)
  );

  // stimulus vectors: byte count, base address, stall cycles per block
  localparam int N_VEC = 16;
  localparam int V_SIZE  [N_VEC] = '{0, 1, 2, 3, 4, 5, 55, 56, 57, 60, 63, 64, 65, 119, 120, 128};
  localparam int V_ADDR  [N_VEC] = '{5, 7, 9, 11, 13, 20, 30, 40, 50, 60, 70, 80, 90, 100, 130, 60};
  localparam int V_STALL [N_VEC] = '{0, 2, 0, 1, 0, 3, 0, 1, 0, 2, 0, 1, 0, 2, 0, 1};

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // padded byte stream built from the requirements
  function automatic logic [7:0] exp_byte(input int s, input int a, input int k);
    int tot = ((s + 8) / 64 + 1) * 64;
    longint unsigned lb = longint'(s) * 8;
    logic [31:0] mw;
    if (k < s) begin
      mw = mem[(a + k / 4) & 255];
      return mw[8*(k%4) +: 8];
    end
    if (k == s) return 8'h80;
    if (k >= tot - 8) return 8'(lb >> (8 * (tot - 1 - k)));
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_word(input int s, input int a, input int b, input int w);
    int k0 = 64 * b + 4 * w;
    return {exp_byte(s, a, k0), exp_byte(s, a, k0 + 1),
            exp_byte(s, a, k0 + 2), exp_byte(s, a, k0 + 3)};
  endfunction

  function automatic string word_tag(input int s, input int b, input int w, input int nb);
    int k0 = 64 * b + 4 * w;
    if (s == 0) return "R12";
    if (b == nb - 1 && w >= 14) return "R7";
    if (s >= k0 && s < k0 + 4) return (s % 4 == 0) ? "R5" : "R4";
    if (k0 >= s) return "R6";
    return (b == 0) ? "R2" : "R3";
  endfunction

  task automatic run_vec(input int vi, input int s, input int a, input int stall, input bit inj);
    int nb = (s + 8) / 64 + 1;
    int rw = (s + 3) / 4;
    int n;
    int extra;
    @(negedge clk);
    msg_addr  = 16'(a);
    msg_bytes = 32'(s);
    start     = 1'b1;
    for (int b = 0; b < nb; b++) begin
      int take = (rw > 16) ? 16 : rw;
      bit data_ok = 1'b1;
      rw -= take;
      n = 0;
      do begin
        @(negedge clk);
        n++;
        if (n == 1) begin
          start     = 1'b0;
          blk_ready = 1'b0;
          msg_addr  = 16'hBEEF;
          msg_bytes = 32'd999;
        end
        if (inj && b == 0 && n == 2) begin
          start     = 1'b1;
          msg_addr  = 16'd200;
          msg_bytes = 32'd0;
        end
        if (n == 3) start = 1'b0;
      end while (!blk_valid && n < 200);
      check(n == take + 3, "R9", $sformatf("vec %0d blk %0d valid delay", vi, b), n, take + 3);
      repeat (stall) @(negedge clk);
      check(blk_valid == 1'b1, "R8", $sformatf("vec %0d blk %0d valid after stall", vi, b), blk_valid, 1);
      for (int w = 0; w < 16; w++) begin
        logic [31:0] ew = exp_word(s, a, b, w);
        if (data_ok && blk_words[32*w +: 32] != ew) begin
          data_ok = 1'b0;
          check(1'b0, word_tag(s, b, w, nb), $sformatf("vec %0d blk %0d word %0d", vi, b, w),
                blk_words[32*w +: 32], ew);
        end
      end
      if (data_ok) check(1'b1, "R3", "block words", 0, 0);
      check(blk_last == (b == nb - 1), "R1", $sformatf("vec %0d blk %0d last flag", vi, b),
            blk_last, (b == nb - 1));
      blk_ready = 1'b1;
    end
    @(negedge clk);
    blk_ready = 1'b0;
    extra = 0;
    repeat (30) begin
      @(negedge clk);
      if (blk_valid) extra++;
    end
    check(extra == 0, inj ? "R10" : "R1", $sformatf("vec %0d cycles with extra block", vi), extra, 0);
  endtask

  initial begin
    int n;
    rst       = 1'b1;
    start     = 1'b0;
    blk_ready = 1'b0;
    msg_addr  = '0;
    msg_bytes = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'(i + 1) * 32'h9E37_79B1 ^ 32'hC3A5_0F1E;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!blk_valid && !blk_last, "R11", "reset state", {blk_valid, blk_last}, 0);
    rst = 1'b0;

    for (int v = 0; v < N_VEC; v++) run_vec(v, V_SIZE[v], V_ADDR[v], V_STALL[v], 1'b0);

    // R10: start strobes during a job are ignored
    run_vec(100, 8, 10, 0, 1'b1);
    run_vec(101, 70, 20, 1, 1'b1);

    // R11: reset while a block is offered, then a fresh job
    @(negedge clk);
    msg_addr  = 16'd40;
    msg_bytes = 32'd100;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!blk_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(blk_valid == 1'b1, "R11", "block offered before reset", blk_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!blk_valid && !blk_last, "R11", "outputs after mid-job reset", {blk_valid, blk_last}, 0);
    rst = 1'b0;
    run_vec(102, 12, 33, 1, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule